// File: doc/BRIEF.md
# USB Device Global Control and Remote Wakeup Sequencer

This block holds the single 8-bit global control register of a USB device controller. It also runs the hardware that signals remote wakeup to the host. Firmware writes the register through a simple write strobe and reads it back combinationally. The register turns the rest of the controller on or off, and it can gate the 48 MHz clock domain. It also records the firmware's view of the device: whether it is configured and whether its assigned function address is in force. A detected bus reset clears that view in hardware, and from then on the effective function address drops back to 0.

Remote wakeup is a short handshake. Firmware first allows wakeup. It then raises a wakeup request, and hardware sets a read-only busy flag. The block waits until three things hold: the bus has been suspended for a minimum number of millisecond ticks, the 48 MHz clock is running, and both wakeup bits are still set. It then drives the resume request for a fixed number of ticks and clears the busy flag. A bus reset, or clearing the enable bit, ends any pending or active wakeup at once.

Top module: `usb_gctl_top`

## Requirements
- R1: After reset, rd_data is 0x00, ctrl_reset is 1, clk48_gate_off is 0, resume_drive is 0 and func_addr is 0.
- R2: Bit layout: bit 7 enable, bit 6 clock gate, bit 5 wakeup request, bit 4 reserved, bit 3 wakeup busy (read only), bit 2 wakeup permit, bit 1 configured, bit 0 address enable. A write with wr_en stores bits 7, 6, 5, 2, 1 and 0 at the clock edge.
- R3: Bit 4 always reads 0. Writes to bit 4 and bit 3 have no effect.
- R4: ctrl_reset equals the inverse of bit 7, and clk48_gate_off equals bit 6.
- R5: func_addr equals prog_addr while bit 0 is 1, and 0 while bit 0 is 0.
- R6: bus_reset clears bits 1 and 0 at the next edge. It wins over a write in the same cycle.
- R7: A write that moves bit 5 from 0 to 1, with bit 2 set in the written data, sets busy (bit 3) at that edge if bit 7 was already 1. A write that leaves bit 5 at 1, or that has bit 2 clear, does not set busy.
- R8: The suspend timer counts ms_tick pulses while bus_suspend is 1. It clears whenever bus_suspend is 0, and it saturates at SUSP_MS ticks (5).
- R9: resume_drive rises one cycle after all of these hold together: busy, bit 5, bit 2, bit 6 clear, and the suspend timer at its threshold.
- R10: resume_drive lasts DRIVE_MS ms_tick pulses (10). On the last one, both resume_drive and busy clear.
- R11: bus_reset, or bit 7 being 0, clears busy and resume_drive at the next edge.
- R12: Bit 5 is never cleared by hardware. It changes only by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read view |
| bus_suspend | input | 1 | Bus is in the suspend state |
| bus_reset | input | 1 | Bus reset detected |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| prog_addr | input | ADDR_W | Programmed function address |
| ctrl_reset | output | 1 | Holds the controller in reset |
| clk48_gate_off | output | 1 | Gates off the 48 MHz clock |
| resume_drive | output | 1 | Request to drive resume upstream |
| func_addr | output | ADDR_W | Effective function address |

## Verification
The bench builds the block with its default parameters: a 5-tick suspend threshold, a 10-tick drive period and a 7-bit address. The threshold and the drive period are short enough to walk tick by tick. It checks the exact cycle in which the drive starts and ends, and it shows that four suspend ticks are not enough. With these values the bench can also cover a gated clock holding back a pending wakeup, an interrupted suspend restarting the count, and aborts both by bus reset and by clearing the enable bit. Randomized register traffic mixed with bus resets covers the bit storage, the reserved bits and the address masking.

// File: rtl/usb_gctl_pkg.sv
package usb_gctl_pkg;

  localparam int B_EN    = 7;
  localparam int B_GATE  = 6;
  localparam int B_WREQ  = 5;
  localparam int B_RSVD  = 4;
  localparam int B_BUSY  = 3;
  localparam int B_WOK   = 2;
  localparam int B_CFG   = 1;
  localparam int B_AEN   = 0;

  typedef struct packed {
    logic en;
    logic gate;
    logic wake_req;
    logic wake_ok;
    logic cfg;
    logic addr_en;
  } ctl_t;

  function automatic ctl_t decode_write(input logic [7:0] d);
    ctl_t c;
    c.en       = d[B_EN];
    c.gate     = d[B_GATE];
    c.wake_req = d[B_WREQ];
    c.wake_ok  = d[B_WOK];
    c.cfg      = d[B_CFG];
    c.addr_en  = d[B_AEN];
    return c;
  endfunction

  function automatic logic [7:0] encode_view(input ctl_t c, input logic busy);
    logic [7:0] v;
    v         = '0;
    v[B_EN]   = c.en;
    v[B_GATE] = c.gate;
    v[B_WREQ] = c.wake_req;
    v[B_RSVD] = 1'b0;
    v[B_BUSY] = busy;
    v[B_WOK]  = c.wake_ok;
    v[B_CFG]  = c.cfg;
    v[B_AEN]  = c.addr_en;
    return v;
  endfunction

endpackage

// File: rtl/gctl_regfile.sv
module gctl_regfile
  import usb_gctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       bus_reset,
  output ctl_t       ctl,
  output logic       wake_start
);

  // A wakeup starts only on a 0->1 move of the request bit with permit set.
  function automatic logic is_wake_start(input logic we, input logic [7:0] d,
                                         input logic cur_req);
    return we && d[B_WREQ] && d[B_WOK] && !cur_req;
  endfunction

  assign wake_start = is_wake_start(wr_en, wr_data, ctl.wake_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (wr_en) ctl <= decode_write(wr_data);
      if (bus_reset) begin
        ctl.cfg     <= 1'b0;
        ctl.addr_en <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/gctl_susp_timer.sv
module gctl_susp_timer #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_suspend,
  input  logic ms_tick,
  output logic reached
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic susp, input logic tick);
    if (!susp)             return '0;
    if (tick && (c != LIM)) return c + 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_count(cnt, bus_suspend, ms_tick);
  end

  assign reached = (cnt == LIM);

endmodule

// File: rtl/gctl_wake_seq.sv
module gctl_wake_seq #(
  parameter int DRIVE_MS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic abort,
  input  logic launch_ok,
  input  logic ms_tick,
  output logic busy,
  output logic drive,
  output logic drive_start,
  output logic drive_done
);

  localparam int DW = $clog2(DRIVE_MS + 1);
  localparam logic [DW-1:0] LAST = DW'(DRIVE_MS - 1);

  logic [DW-1:0] dcnt;

  assign drive_start = busy && !drive && launch_ok && !abort;
  assign drive_done  = drive && ms_tick && (dcnt == LAST) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      drive <= 1'b0;
      dcnt  <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
      drive <= 1'b0;
      dcnt  <= '0;
    end else begin
      if (start_req) busy <= 1'b1;
      if (drive_start) begin
        drive <= 1'b1;
        dcnt  <= '0;
      end
      if (drive && ms_tick) begin
        if (drive_done) begin
          drive <= 1'b0;
          busy  <= 1'b0;
          dcnt  <= '0;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/usb_gctl_top.sv
module usb_gctl_top
  import usb_gctl_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int SUSP_MS  = 5,
  parameter int DRIVE_MS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              bus_suspend,
  input  logic              bus_reset,
  input  logic              ms_tick,
  input  logic [ADDR_W-1:0] prog_addr,
  output logic              ctrl_reset,
  output logic              clk48_gate_off,
  output logic              resume_drive,
  output logic [ADDR_W-1:0] func_addr
);

  ctl_t ctl;
  logic wake_start;
  logic susp_long;
  logic launch_ok;
  logic abort;
  logic busy;
  logic drive_start;
  logic drive_done;

  function automatic logic [ADDR_W-1:0] eff_addr(input logic aen,
                                                 input logic [ADDR_W-1:0] a);
    return aen ? a : '0;
  endfunction

  gctl_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .bus_reset  (bus_reset),
    .ctl        (ctl),
    .wake_start (wake_start)
  );

  gctl_susp_timer #(.LIMIT(SUSP_MS)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_suspend (bus_suspend),
    .ms_tick     (ms_tick),
    .reached     (susp_long)
  );

  assign abort     = bus_reset || !ctl.en;
  assign launch_ok = susp_long && !ctl.gate && ctl.wake_req && ctl.wake_ok;

  gctl_wake_seq #(.DRIVE_MS(DRIVE_MS)) u_wake (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (wake_start),
    .abort       (abort),
    .launch_ok   (launch_ok),
    .ms_tick     (ms_tick),
    .busy        (busy),
    .drive       (resume_drive),
    .drive_start (drive_start),
    .drive_done  (drive_done)
  );

  assign rd_data        = encode_view(ctl, busy);
  assign ctrl_reset     = !ctl.en;
  assign clk48_gate_off = ctl.gate;
  assign func_addr      = eff_addr(ctl.addr_en, prog_addr);

endmodule

// File: rtl/gctl_checker.sv
module gctl_checker #(
  parameter int ADDR_W   = 7,
  parameter int DRIVE_MS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              bus_reset,
  input logic              ms_tick,
  input logic [7:0]        rd_data,
  input logic [ADDR_W-1:0] func_addr,
  input logic              resume_drive,
  input logic              susp_long,
  input logic              abort,
  input logic              drive_done
);

  localparam int CW = $clog2(DRIVE_MS + 2);
  logic [CW-1:0] tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      tick_cnt <= '0;
    else if (!resume_drive)          tick_cnt <= '0;
    else if (ms_tick)                tick_cnt <= tick_cnt + 1'b1;
  end

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] == 1'b0);

  p_addr_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |-> func_addr == '0);

  p_busrst_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (rd_data[1:0] == 2'b00));

  p_drive_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_drive) |-> $past(susp_long && !rd_data[6] && rd_data[5] && rd_data[2]));

  p_drive_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_drive |-> rd_data[3]);

  p_drive_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt <= CW'(DRIVE_MS));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!resume_drive && !rd_data[3]));

  p_busy_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[3]) |-> $past(abort || drive_done));

  p_wreq_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[5]) |-> $past(wr_en));

endmodule

bind usb_gctl_top gctl_checker #(.ADDR_W(ADDR_W), .DRIVE_MS(DRIVE_MS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .bus_reset    (bus_reset),
  .ms_tick      (ms_tick),
  .rd_data      (rd_data),
  .func_addr    (func_addr),
  .resume_drive (resume_drive),
  .susp_long    (susp_long),
  .abort        (abort),
  .drive_done   (drive_done)
);

// File: tb/tb_usb_gctl_top.sv
module tb_usb_gctl_top;

  localparam int ADDR_W = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_data = '0;
  logic [7:0]        rd_data;
  logic              bus_suspend = 1'b0;
  logic              bus_reset = 1'b0;
  logic              ms_tick = 1'b0;
  logic [ADDR_W-1:0] prog_addr = 7'h35;
  logic              ctrl_reset;
  logic              clk48_gate_off;
  logic              resume_drive;
  logic [ADDR_W-1:0] func_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  usb_gctl_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .bus_suspend(bus_suspend), .bus_reset(bus_reset), .ms_tick(ms_tick),
    .prog_addr(prog_addr), .ctrl_reset(ctrl_reset), .clk48_gate_off(clk48_gate_off),
    .resume_drive(resume_drive), .func_addr(func_addr)
  );

  always #10 clk = ~clk;

  // Expected register view: reserved bits cleared, busy inserted.
  function automatic logic [7:0] exp_view(input logic [7:0] stored, input logic busy);
    return (stored & 8'hE7) | (busy ? 8'h08 : 8'h00);
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(input logic [7:0] view,
                                                 input logic [ADDR_W-1:0] a);
    return view[0] ? a : '0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All stimulus tasks start and end at a falling edge.
  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      @(posedge clk); #1 ms_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic breset();
    bus_reset = 1'b1;
    @(posedge clk); #1 bus_reset = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] model;
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 rd", rd_data, 8'h00);
    check("R1 ctrl_reset", ctrl_reset, 1'b1);
    check("R1 gate", clk48_gate_off, 1'b0);
    check("R1 drive", resume_drive, 1'b0);
    check("R1 addr", func_addr, 0);

    wr(8'h80);
    check("R2 enable store", rd_data, 8'h80);
    check("R4 ctrl_reset low", ctrl_reset, 1'b0);

    // R3 reserved/busy writes ignored, R7 busy sets on request rise with permit
    wr(8'hBF);
    check("R3 R7 view", rd_data, 8'hAF);
    check("R5 addr enabled", func_addr, prog_addr);
    check("R9 no drive without suspend", resume_drive, 1'b0);

    // R8 four ticks not enough
    bus_suspend = 1'b1;
    tick(4);
    idle(1);
    check("R8 four ticks", resume_drive, 1'b0);
    // R9 gated clock holds the wakeup pending
    wr(8'hE7);
    check("R4 gate out", clk48_gate_off, 1'b1);
    tick(1);
    idle(1);
    check("R9 gated no drive", resume_drive, 1'b0);
    check("R9 still busy", rd_data, 8'hEF);
    wr(8'hA7);
    check("R9 drive one cycle later", resume_drive, 1'b0);
    idle(1);
    check("R9 drive started", resume_drive, 1'b1);

    // R10 drive length
    tick(9);
    check("R10 drive at tick 9", resume_drive, 1'b1);
    check("R10 busy at tick 9", rd_data[3], 1'b1);
    tick(1);
    check("R10 drive end", resume_drive, 1'b0);
    check("R10 R12 view after end", rd_data, exp_view(8'hA7, 1'b0));
    idle(3);
    check("R7 no retrigger while request held", rd_data, 8'hA7);
    check("R12 request sticky", resume_drive, 1'b0);

    // R11 abort by bus reset, R6 clears flags
    wr(8'h87);
    wr(8'hA7);
    check("R7 busy again", rd_data, 8'hAF);
    idle(1);
    check("R9 drive immediately", resume_drive, 1'b1);
    breset();
    check("R11 bus reset abort drive", resume_drive, 1'b0);
    check("R6 R11 view", rd_data, 8'hA4);
    check("R5 addr zero after reset", func_addr, 0);

    // R11 abort by enable clear
    wr(8'h84);
    wr(8'hA4);
    check("R7 busy set", rd_data, 8'hAC);
    idle(1);
    check("R9 drive", resume_drive, 1'b1);
    wr(8'h24);
    idle(1);
    check("R11 enable abort drive", resume_drive, 1'b0);
    check("R11 enable abort view", rd_data, 8'h24);
    check("R4 ctrl_reset high", ctrl_reset, 1'b1);

    // R8 interrupted suspend restarts count
    wr(8'h84);
    bus_suspend = 1'b0;
    idle(1);
    bus_suspend = 1'b1;
    wr(8'hA4);
    tick(4);
    idle(1);
    check("R8 restart count", resume_drive, 1'b0);
    tick(1);
    idle(1);
    check("R8 threshold reached", resume_drive, 1'b1);
    breset();

    // R7 no busy when permit clear in the written data
    wr(8'h80);
    wr(8'hA0);
    check("R7 permit clear no busy", rd_data, 8'hA0);
    bus_suspend = 1'b0;

    // R2 R3 R4 R5 R6 random traffic; request bit held low so no wakeup starts
    model = 8'hA0;
    for (int i = 0; i < 150; i++) begin
      logic [7:0] d;
      logic we, br;
      d  = 8'($urandom) & 8'hDF;
      we = ($urandom % 4) != 0;
      br = ($urandom % 5) == 0;
      prog_addr = ADDR_W'($urandom);
      wr_en = we; wr_data = d; bus_reset = br;
      @(posedge clk); #1 wr_en = 1'b0; bus_reset = 1'b0;
      @(negedge clk);
      if (we) model = exp_view(d, 1'b0);
      if (br) model = model & 8'hFC;
      check("R2 R3 R6 random view", rd_data, model);
      check("R5 random addr", func_addr, exp_addr(model, prog_addr));
      check("R4 random ctrl", {ctrl_reset, clk48_gate_off}, {~model[7], model[6]});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule